// File: doc/BRIEF.md
# I/O Activity Timeout Power Monitor

This block watches a processor I/O bus for accesses that land inside one programmed address window. Each such access restarts an inactivity timer. If the window stays quiet for the programmed number of prescaled ticks, the block raises a power-off request. A power-control pin can use that request to remove supply from the peripheral that lives behind the window.

Once the peripheral is off, any later access to its window raises a management interrupt request. Software can then find out why the interrupt happened, restore power and clear the request. The request stays set until software clears it with a write-one-to-clear pulse. Restoring power is a separate software pulse, and that pulse also restarts the timer. A global enable, when low, holds the timer at its reload value and forces both outputs low.

The timer counts on a tick taken from an internal prescaler that divides the clock by `PRESCALE`. Every reload also restarts the prescaler, so the timeout length is exact: it is `(reload_val + 1) * PRESCALE` clock edges, counted from the edge that performed the reload.

Top module: `iomon_power_gate`

## Requirements
- R1: An access matches when `bus_valid` is high and `((bus_addr ^ range_base) & range_mask) == 0`. A mask bit of 0 makes that address bit a don't-care. With `bus_valid` low, nothing matches.
- R2: A matching access sampled at clock edge e0 reloads the timer and restarts the prescaler. If no further reload happens, `pwr_off` is first high after edge e0 + (reload_val+1)*PRESCALE, and is low after every earlier edge.
- R3: Accesses that do not match have no effect on when the timeout happens.
- R4: `pwr_off` stays high until a `restore_wr` pulse. It is low after the edge that samples `restore_wr`. That edge also reloads the timer, so the next timeout follows R2, counted from that edge.
- R5: A matching access sampled while `pwr_off` is high sets `smi_req` after that edge. A matching access while `pwr_off` is low does not set it.
- R6: `smi_req` is sticky and is cleared only by a `smi_clr` pulse. If a new setting access and `smi_clr` arrive at the same edge, the set wins.
- R7: While `enable` is low, both outputs are low after each edge and the timer is held at its reload value. When `enable` goes high, the timeout follows R2, counted from the last edge that sampled `enable` low. Both outputs are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Global enable of the monitor |
| range_base | input | AW | Base address of the watched window |
| range_mask | input | AW | Compare mask; 1 = bit must equal base |
| reload_val | input | TW | Timeout reload count in prescaled ticks |
| bus_valid | input | 1 | An I/O access is present this cycle |
| bus_addr | input | AW | Address of the I/O access |
| restore_wr | input | 1 | Software pulse: power back on, reload timer |
| smi_clr | input | 1 | Write-one-to-clear of the interrupt flag |
| pwr_off | output | 1 | Registered power-off request |
| smi_req | output | 1 | Registered sticky management interrupt request |

## Verification
The bench builds the block with an 8-bit address, a 4-bit timer and a prescale of 4. That makes three sweeps exhaustive. The first offers all 256 addresses against three base and mask pairs while the peripheral is off, so the compare rule is checked bit by bit through the interrupt flag. The second covers reload values 0 to 5, checking the exact timeout edge for each. The third repeats the timeout count after each kind of reload: a matching access, a restore write and the enable rising. Bus noise, the set-versus-clear collision and behaviour while disabled are each checked on their own.

// File: rtl/iomon_pkg.sv
package iomon_pkg;
  typedef enum logic [1:0] {
    TMR_RELOAD = 2'd0,
    TMR_HOLD   = 2'd1,
    TMR_COUNT  = 2'd2
  } tmr_action_e;
endpackage

// File: rtl/iomon_addr_match.sv
module iomon_addr_match #(
  parameter int AW = 16
) (
  input  logic          valid,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] mask,
  output logic          hit
);
  logic [AW-1:0] diff;

  genvar i;
  generate
    for (i = 0; i < AW; i++) begin : g_bit
      assign diff[i] = (addr[i] ^ base[i]) & mask[i];
    end
  endgenerate

  assign hit = valid & ~(|diff);
endmodule

// File: rtl/iomon_prescaler.sv
module iomon_prescaler #(
  parameter int PRESCALE = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] phase;

  assign tick = run & ~restart & (phase == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart || !run) begin
      phase <= '0;
    end else if (phase == LAST) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end
endmodule

// File: rtl/iomon_idle_timer.sv
module iomon_idle_timer
  import iomon_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  tmr_action_e   action,
  input  logic          tick,
  input  logic [TW-1:0] reload_val,
  output logic          expire
);
  logic [TW-1:0] remain;

  assign expire = (action == TMR_COUNT) & tick & (remain == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
    end else begin
      unique case (action)
        TMR_RELOAD: remain <= reload_val;
        TMR_HOLD:   remain <= remain;
        default: begin
          if (tick && remain != '0) remain <= remain - 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/iomon_power_gate.sv
module iomon_power_gate
  import iomon_pkg::*;
#(
  parameter int AW       = 16,
  parameter int TW       = 16,
  parameter int PRESCALE = 256
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic [AW-1:0] range_base,
  input  logic [AW-1:0] range_mask,
  input  logic [TW-1:0] reload_val,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic          restore_wr,
  input  logic          smi_clr,
  output logic          pwr_off,
  output logic          smi_req
);
  logic        hit;
  logic        restart;
  logic        tick;
  logic        expire;
  tmr_action_e action;

  iomon_addr_match #(.AW(AW)) u_match (
    .valid (bus_valid),
    .addr  (bus_addr),
    .base  (range_base),
    .mask  (range_mask),
    .hit   (hit)
  );

  assign restart = ~enable | hit | restore_wr;

  always_comb begin
    if (restart)      action = TMR_RELOAD;
    else if (pwr_off) action = TMR_HOLD;
    else              action = TMR_COUNT;
  end

  iomon_prescaler #(.PRESCALE(PRESCALE)) u_presc (
    .clk     (clk),
    .rst     (rst),
    .run     (enable),
    .restart (restart),
    .tick    (tick)
  );

  iomon_idle_timer #(.TW(TW)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .action     (action),
    .tick       (tick),
    .reload_val (reload_val),
    .expire     (expire)
  );

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      pwr_off <= 1'b0;
      smi_req <= 1'b0;
    end else begin
      if (restore_wr)  pwr_off <= 1'b0;
      else if (expire) pwr_off <= 1'b1;

      if (hit && pwr_off) smi_req <= 1'b1;
      else if (smi_clr)   smi_req <= 1'b0;
    end
  end
endmodule

// File: rtl/iomon_power_gate_chk.sv
module iomon_power_gate_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          enable,
  input logic [AW-1:0] range_base,
  input logic [AW-1:0] range_mask,
  input logic          bus_valid,
  input logic [AW-1:0] bus_addr,
  input logic          restore_wr,
  input logic          smi_clr,
  input logic          pwr_off,
  input logic          smi_req
);
  logic in_range;
  assign in_range = bus_valid && (((bus_addr ^ range_base) & range_mask) == '0);

  // R5
  smi_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(smi_req) |-> $past(in_range && pwr_off && enable));

  // R5
  smi_set_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && in_range && pwr_off) |=> smi_req);

  // R6
  smi_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (smi_req && enable && !smi_clr) |=> smi_req);

  // R4
  off_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pwr_off) |-> $past(restore_wr || !enable));

  // R2
  off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_off) |-> $past(!in_range && !restore_wr && enable));

  // R7
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!pwr_off && !smi_req));
endmodule

bind iomon_power_gate iomon_power_gate_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .enable     (enable),
  .range_base (range_base),
  .range_mask (range_mask),
  .bus_valid  (bus_valid),
  .bus_addr   (bus_addr),
  .restore_wr (restore_wr),
  .smi_clr    (smi_clr),
  .pwr_off    (pwr_off),
  .smi_req    (smi_req)
);

// File: tb/tb_iomon_power_gate.sv
module tb_iomon_power_gate;
  localparam int AW = 8;
  localparam int TW = 4;
  localparam int P  = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          enable = 1'b0;
  logic [AW-1:0] range_base = 8'h50;
  logic [AW-1:0] range_mask = 8'hF0;
  logic [TW-1:0] reload_val = '0;
  logic          bus_valid = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          restore_wr = 1'b0;
  logic          smi_clr = 1'b0;
  logic          pwr_off;
  logic          smi_req;
  logic          noise = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  iomon_power_gate #(.AW(AW), .TW(TW), .PRESCALE(P)) dut (
    .clk(clk), .rst(rst), .enable(enable),
    .range_base(range_base), .range_mask(range_mask), .reload_val(reload_val),
    .bus_valid(bus_valid), .bus_addr(bus_addr),
    .restore_wr(restore_wr), .smi_clr(smi_clr),
    .pwr_off(pwr_off), .smi_req(smi_req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int in_win(input int a, input int b, input int m);
    return (((a ^ b) & m) == 0) ? 1 : 0;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    if (noise) begin
      bus_valid = 1'b1;
      bus_addr  = 8'h65;
    end
  endtask

  // Counts edges after the reload edge; checks the exact timeout edge.
  task automatic count_timeout(input string tag, input int r);
    int exp = (r + 1) * P;
    for (int k = 1; k <= exp; k++) begin
      step();
      if (k >= exp - 1) chk(tag, int'(pwr_off), (k >= exp) ? 1 : 0);
    end
  endtask

  task automatic pulse_hit();
    bus_valid = 1'b1;
    bus_addr  = range_base;
    step();
    bus_valid = 1'b0;
  endtask

  task automatic pulse_restore();
    restore_wr = 1'b1;
    step();
    restore_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
        finish_run();
      end
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R7 reset pwr_off", int'(pwr_off), 0);
    chk("R7 reset smi_req", int'(smi_req), 0);
    enable = 1'b1;

    // R2 exact timeout for each reload value; R3 with bus noise
    for (int r = 0; r <= 5; r++) begin
      reload_val = TW'(r);
      pulse_restore();
      step();
      pulse_hit();
      noise = (r == 3 || r == 5);
      count_timeout((r == 3 || r == 5) ? "R3 noise timeout" : "R2 timeout", r);
      noise = 1'b0;
      bus_valid = 1'b0;
    end

    // R4 stays off, restore clears and reloads
    reload_val = 4'd2;
    repeat (6) step();
    chk("R4 held off", int'(pwr_off), 1);
    restore_wr = 1'b1;
    step();
    restore_wr = 1'b0;
    chk("R4 restore clears", int'(pwr_off), 0);
    count_timeout("R4 timeout after restore", 2);

    // R5 no interrupt while powered on
    reload_val = 4'd15;
    pulse_restore();
    pulse_hit();
    chk("R5 no smi when on", int'(smi_req), 0);

    // R1 and R5 exhaustive address sweep while off
    reload_val = 4'd0;
    pulse_restore();
    repeat (2 * P) step();
    chk("R1 off for sweep", int'(pwr_off), 1);
    for (int c = 0; c < 3; c++) begin
      range_base = (c == 0) ? 8'h50 : (c == 1) ? 8'hA5 : 8'h3C;
      range_mask = (c == 0) ? 8'hF0 : (c == 1) ? 8'h0F : 8'h00;
      for (int a = 0; a < 256; a++) begin
        bus_valid = 1'b1;
        bus_addr  = AW'(a);
        step();
        bus_valid = 1'b0;
        chk("R1 R5 match sweep", int'(smi_req),
            in_win(a, int'(range_base), int'(range_mask)));
        if (smi_req) begin
          smi_clr = 1'b1;
          step();
          smi_clr = 1'b0;
        end
      end
    end
    range_base = 8'h50;
    range_mask = 8'hF0;

    // R1 matching address without valid
    bus_addr = 8'h57;
    step();
    chk("R1 valid required", int'(smi_req), 0);

    // R6 sticky, set wins over clear, then clear
    pulse_hit();
    repeat (3) step();
    chk("R6 sticky", int'(smi_req), 1);
    smi_clr = 1'b1;
    pulse_hit();
    chk("R6 set beats clear", int'(smi_req), 1);
    step();
    smi_clr = 1'b0;
    chk("R6 clear", int'(smi_req), 0);
    pulse_hit();

    // R7 disable
    enable = 1'b0;
    step();
    chk("R7 disabled pwr_off", int'(pwr_off), 0);
    chk("R7 disabled smi_req", int'(smi_req), 0);
    pulse_hit();
    repeat (3 * P) step();
    chk("R7 no timeout while disabled", int'(pwr_off), 0);
    chk("R7 no smi while disabled", int'(smi_req), 0);
    reload_val = 4'd3;
    step();
    enable = 1'b1;
    count_timeout("R7 timeout after enable", 3);

    finish_run();
  end
endmodule